// File: doc/BRIEF.md
# Tiny I2C Serial Memory Slave Engine

This block is the command engine of a 16-word by 8-bit memory that sits on an I2C bus as a slave. It runs on a system clock that oversamples the bus. A front-end supplies single-cycle event pulses: start, stop, SCL rising edge and SCL falling edge. It also supplies the sampled SDA level, which is valid with each rising edge. The engine returns one output, the enable for the open-drain SDA pull-down.

The engine decodes the control byte, the word address and the data bytes. It supports four operations: byte write, current-address read, random read through a repeated start, and sequential read. A committed write starts a self-timed write cycle whose length is a parameter in system clocks. During that cycle the engine stays silent on the bus, so the master can use acknowledge polling. A low-supply input flag blocks every store.

Top module: `eepromSlave`

## Requirements
- R1: After reset the SDA pull-down is released, every word holds 0x00, the address pointer is 0 and no write cycle is running. A current-address read therefore returns 0x00 from word 0.
- R2: Bytes are received MSB first, one bit per SCL rising edge. A control byte has the form 1010 in bits 7..4, don't-care bits 3..1, and read (1) or write (0) in bit 0. It is acknowledged only when the code matches and no write cycle is running. The acknowledge is a pull-down held from the falling edge after bit 8 until the falling edge after the ninth clock. An unacknowledged control byte makes the engine ignore the bus until the next start.
- R3: Byte write follows this order: a write control byte, a word address byte, a data byte (each acknowledged), then a stop. This stores the data at the word named by address bits 3..0. Address bits 7..4 have no effect.
- R4: After a byte write the pointer stays on the word just written. A following current-address read returns that byte.
- R5: A committed write starts a write cycle of WRITE_CYCLES system clocks. During the cycle, control bytes get no acknowledge even when the code matches. After the cycle they are acknowledged again.
- R6: A stop that arrives before the eighth bit of the data byte aborts the write. Nothing is stored and no write cycle starts.
- R7: If data bytes continue past the first one, each complete byte replaces the previous one, and the last complete byte is stored at the stop. A stop that arrives partway through a later byte aborts the write, and nothing is stored.
- R8: After an acknowledged read control byte, the engine sends the word at the pointer MSB first. Each bit is driven after an SCL falling edge, with the pull-down enabled for a 0 bit. The pointer then advances by one.
- R9: Random read works as follows. A write control byte and a word address set the pointer. A repeated start and a read control byte then return the word at that address, and the pointer moves on to the next address.
- R10: While the master acknowledges (SDA low on the ninth clock), the engine keeps sending successive words, and the pointer wraps from 15 to 0. After a master no-acknowledge, the engine releases SDA and ignores the bus until the next start.
- R11: If the low-supply flag is high when the stop arrives, the write is inhibited: nothing is stored and no write cycle starts.
- R12: The SDA pull-down changes only in response to an SCL falling edge, a start or a stop. A start or a stop always releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| startDet | input | 1 | One-cycle pulse: start or repeated start seen |
| stopDet | input | 1 | One-cycle pulse: stop seen |
| sclRise | input | 1 | One-cycle pulse: SCL rising edge |
| sclFall | input | 1 | One-cycle pulse: SCL falling edge |
| sdaIn | input | 1 | Sampled SDA level, valid with sclRise |
| lowSupply | input | 1 | High while the supply is too low for storing |
| sdaPullDown | output | 1 | 1 enables the open-drain pull-down on SDA |

## Verification
A wrong parse state or a wrong busy state shows up within one byte, on the ninth clock of that byte. A missing acknowledge, a spurious acknowledge, or a pull-down during a master-owned bit is visible on sdaPullDown right after the eighth falling edge. Pointer or storage faults stay hidden until the next read. The bench therefore follows each write, abort and inhibited write with a read-back, and it probes acknowledge polling both immediately after a stop and after the write cycle has ended.

// File: rtl/eepSlavePkg.sv
package eepSlavePkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } parseState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // shift one received bit into the receive register
    logic bitVal;    // value of that bit
    logic loadPtr;   // take word address from receive register
    logic loadTx;    // fetch word at pointer into transmit register, advance pointer
    logic commit;    // store receive register at pointer
  } dpStrobe_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/eepWriteTimer.sv
module eepWriteTimer #(
  parameter int WRITE_CYCLES = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic startCycle,
  output logic busy
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
    end else if (startCycle) begin
      remaining <= CNT_W'(WRITE_CYCLES);
    end else if (remaining != '0) begin
      remaining <= remaining - 1'b1;
    end
  end

  assign busy = (remaining != '0);

endmodule

// File: rtl/eepSlaveData.sv
module eepSlaveData
  import eepSlavePkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  output logic [3:0]        rxCode,
  output logic              rxRw,
  output logic [DATA_W-1:0] txByte
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] rxByte;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] rdArr [DEPTH];

  // storage words, one register each with its own write enable
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        word <= '0;
      end else if (stb.commit && (ptr == ADDR_W'(w))) begin
        word <= rxByte;
      end
    end
    assign rdArr[w] = word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
    end else if (stb.shiftIn) begin
      rxByte <= {rxByte[DATA_W-2:0], stb.bitVal};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      txByte <= '0;
    end else if (stb.loadPtr) begin
      ptr <= rxByte[ADDR_W-1:0];
    end else if (stb.loadTx) begin
      txByte <= rdArr[ptr];
      ptr    <= ptr + 1'b1;
    end
  end

  assign rxCode = rxByte[DATA_W-1 -: 4];
  assign rxRw   = rxByte[0];

endmodule

// File: rtl/eepSlaveCtrl.sv
module eepSlaveCtrl
  import eepSlavePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaIn,
  input  logic              lowSupply,
  input  logic              busy,
  input  logic [3:0]        rxCode,
  input  logic              rxRw,
  input  logic [DATA_W-1:0] txByte,
  output dpStrobe_t         stb,
  output logic              timerStart,
  output logic              sdaPullDown
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] MSB_IDX   = IDX_W'(DATA_W - 1);

  parseState_t      state;
  logic [CNT_W-1:0] bitCnt;
  logic             ackGiven;
  logic             dataValid;
  logic             pullReg;

  logic edgeRise, edgeFall, rxState, ackRise, ackNow;
  logic [IDX_W-1:0] txIdx;

  assign edgeRise = sclRise && !startDet && !stopDet;
  assign edgeFall = sclFall && !startDet && !stopDet && !sclRise;
  assign rxState  = (state == ST_CTRL) || (state == ST_WADDR) || (state == ST_WDATA);
  assign ackRise  = edgeRise && (bitCnt == ACK_SLOT);
  assign txIdx    = MSB_IDX - bitCnt[IDX_W-1:0];

  // acknowledge decision for the ninth clock of a received byte
  always_comb begin
    case (state)
      ST_CTRL:  ackNow = (rxCode == DEV_CODE) && !busy;
      ST_WADDR: ackNow = 1'b1;
      ST_WDATA: ackNow = 1'b1;
      default:  ackNow = 1'b0;
    endcase
  end

  always_comb begin
    stb         = '0;
    stb.shiftIn = edgeRise && rxState && (bitCnt < ACK_SLOT);
    stb.bitVal  = sdaIn;
    stb.loadPtr = ackRise && (state == ST_WADDR);
    stb.loadTx  = ackRise && (((state == ST_CTRL) && ackGiven && rxRw) ||
                              ((state == ST_RDATA) && !sdaIn));
    stb.commit  = stopDet && !startDet && (state == ST_WDATA) && dataValid &&
                  !lowSupply && !busy;
  end

  assign timerStart  = stb.commit;
  assign sdaPullDown = pullReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackGiven  <= 1'b0;
      dataValid <= 1'b0;
      pullReg   <= 1'b0;
    end else if (startDet) begin
      state     <= ST_CTRL;
      bitCnt    <= '0;
      ackGiven  <= 1'b0;
      dataValid <= 1'b0;
      pullReg   <= 1'b0;
    end else if (stopDet) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackGiven  <= 1'b0;
      dataValid <= 1'b0;
      pullReg   <= 1'b0;
    end else if (edgeRise) begin
      bitCnt <= (bitCnt == ACK_SLOT) ? '0 : bitCnt + 1'b1;
      if (state == ST_WDATA) begin
        if (bitCnt == '0) begin
          dataValid <= 1'b0;
        end else if (bitCnt == LAST_BIT) begin
          dataValid <= 1'b1;
        end
      end
      if (ackRise) begin
        case (state)
          ST_CTRL:  state <= !ackGiven ? ST_IDLE : (rxRw ? ST_RDATA : ST_WADDR);
          ST_WADDR: state <= ST_WDATA;
          ST_WDATA: state <= ST_WDATA;
          ST_RDATA: state <= sdaIn ? ST_IDLE : ST_RDATA;
          default:  state <= ST_IDLE;
        endcase
      end
    end else if (edgeFall) begin
      if (bitCnt == ACK_SLOT) begin
        pullReg  <= ackNow;
        ackGiven <= ackNow;
      end else if (state == ST_RDATA) begin
        pullReg <= ~txByte[txIdx];
      end else begin
        pullReg <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/eepromSlave.sv
module eepromSlave
  import eepSlavePkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic startDet,
  input  logic stopDet,
  input  logic sclRise,
  input  logic sclFall,
  input  logic sdaIn,
  input  logic lowSupply,
  output logic sdaPullDown
);
  dpStrobe_t         stb;
  logic [3:0]        rxCode;
  logic              rxRw;
  logic [DATA_W-1:0] txByte;
  logic              timerStart;
  logic              writeBusy;
  logic              commitStb;

  assign commitStb = stb.commit;

  eepSlaveCtrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaIn),
    .lowSupply(lowSupply), .busy(writeBusy),
    .rxCode(rxCode), .rxRw(rxRw), .txByte(txByte),
    .stb(stb), .timerStart(timerStart), .sdaPullDown(sdaPullDown)
  );

  eepSlaveData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rxCode(rxCode), .rxRw(rxRw), .txByte(txByte)
  );

  eepWriteTimer #(.WRITE_CYCLES(WRITE_CYCLES)) i_timer (
    .clk(clk), .rstN(rstN), .startCycle(timerStart), .busy(writeBusy)
  );

endmodule

// File: rtl/eepSlaveChecker.sv
module eepSlaveChecker (
  input logic clk,
  input logic rstN,
  input logic startDet,
  input logic stopDet,
  input logic sclFall,
  input logic lowSupply,
  input logic sdaPullDown,
  input logic busy,
  input logic commit
);
  // R12
  pull_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullDown != $past(sdaPullDown)) |-> $past(sclFall || startDet || stopDet));

  // R12
  frame_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startDet || stopDet) |=> !sdaPullDown);

  // R11
  low_supply_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> !lowSupply);

  // R5
  no_commit_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> !busy);

  // R5
  busy_follows_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> busy);

  // R6
  busy_only_from_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(commit));

endmodule

bind eepromSlave eepSlaveChecker i_chk (
  .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
  .sclFall(sclFall), .lowSupply(lowSupply), .sdaPullDown(sdaPullDown),
  .busy(writeBusy), .commit(commitStb)
);

// File: tb/test_eepromSlave.sv
module test_eepromSlave;
  localparam int WCYC = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startDet = 1'b0, stopDet = 1'b0, sclRise = 1'b0, sclFall = 1'b0;
  logic sdaDrive = 1'b1, lowSupply = 1'b0;
  logic sdaIn;
  logic sdaPullDown;

  assign sdaIn = sdaDrive & ~sdaPullDown;

  eepromSlave #(.WRITE_CYCLES(WCYC)) i_eepromSlave (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaIn),
    .lowSupply(lowSupply), .sdaPullDown(sdaPullDown)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] refMem [16];
  int refPtr = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doStart();
    @(negedge clk) startDet = 1'b1;
    @(negedge clk) startDet = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic doStop();
    @(negedge clk) stopDet = 1'b1;
    @(negedge clk) stopDet = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // one SCL pulse; seen = pull-down level while SCL was high
  task automatic clockBit(input logic b, output logic seen);
    @(negedge clk) sdaDrive = b;
    repeat (2) @(negedge clk);
    seen = sdaPullDown;
    sclRise = 1'b1;
    @(negedge clk) sclRise = 1'b0;
    repeat (2) @(negedge clk);
    sclFall = 1'b1;
    @(negedge clk) sclFall = 1'b0;
    @(negedge clk) sdaDrive = 1'b1;
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) clockBit(v[i], s);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s);
    clockBit(1'b1, s);
    acked = s;
  endtask

  task automatic readByte(input logic masterAck, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      v[i] = ~s;
    end
    clockBit(~masterAck, s);
  endtask

  function automatic logic [7:0] ctrlByte(input logic rd);
    return {4'b1010, 3'($urandom), rd};
  endfunction

  task automatic byteWrite(input logic [7:0] addr, input logic [7:0] data, input string tag);
    logic a0, a1, a2;
    doStart();
    sendByte(ctrlByte(1'b0), a0);
    sendByte(addr, a1);
    sendByte(data, a2);
    doStop();
    check(a0 && a1 && a2, tag, {a0, a1, a2}, 3'b111);
    if (!lowSupply) refMem[addr[3:0]] = data;
    refPtr = int'(addr[3:0]);
  endtask

  task automatic currentRead(input string tag);
    logic a;
    logic [7:0] d;
    doStart();
    sendByte(ctrlByte(1'b1), a);
    readByte(1'b0, d);
    doStop();
    check(a && d == refMem[refPtr], tag, d, refMem[refPtr]);
    refPtr = (refPtr + 1) % 16;
  endtask

  task automatic randomRead(input logic [7:0] addr, input string tag);
    logic a0, a1, a2;
    logic [7:0] d;
    doStart();
    sendByte(ctrlByte(1'b0), a0);
    sendByte(addr, a1);
    doStart();
    sendByte(ctrlByte(1'b1), a2);
    readByte(1'b0, d);
    doStop();
    check(a0 && a1 && a2 && d == refMem[addr[3:0]], tag, d, refMem[addr[3:0]]);
    refPtr = (int'(addr[3:0]) + 1) % 16;
  endtask

  task automatic pollAck(output logic a);
    doStart();
    sendByte(ctrlByte(1'b0), a);
    doStop();
  endtask

  task automatic waitWrite();
    repeat (WCYC + 20) @(negedge clk);
  endtask

  initial begin
    logic a, s;
    logic [7:0] d;
    void'($urandom(32'd20250611));
    for (int i = 0; i < 16; i++) refMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check(sdaPullDown == 1'b0, "R1 pull-down released", sdaPullDown, 0);
    currentRead("R1 R8 current read after reset");

    // R2 wrong device code: no ack, following bytes ignored
    doStart();
    sendByte(8'hB0, a);
    check(a == 1'b0, "R2 mismatched code not acked", a, 0);
    sendByte(8'h05, a);
    check(a == 1'b0, "R2 bus ignored after nack", a, 0);
    doStop();

    // R3 upper address bits ignored; R5 polling
    byteWrite(8'hF3, 8'h5A, "R2 R3 byte write acks");
    pollAck(a);
    check(a == 1'b0, "R5 no ack during write cycle", a, 0);
    waitWrite();
    pollAck(a);
    check(a == 1'b1, "R5 ack after write cycle", a, 1);
    currentRead("R4 pointer stays on written word");
    randomRead(8'h03, "R3 R9 random read of written word");
    currentRead("R9 pointer advanced after random read");

    // R6 abort before data byte complete
    doStart();
    sendByte(ctrlByte(1'b0), a);
    sendByte(8'h07, a);
    sendBits(8'hFF, 4);
    doStop();
    pollAck(a);
    check(a == 1'b1, "R6 abort starts no write cycle", a, 1);
    randomRead(8'h07, "R6 aborted write stores nothing");

    // R7 reload with later complete byte
    doStart();
    sendByte(ctrlByte(1'b0), a);
    sendByte(8'h08, a);
    sendByte(8'h11, a);
    sendByte(8'h22, a);
    check(a == 1'b1, "R7 second data byte acked", a, 1);
    doStop();
    refMem[8] = 8'h22;
    waitWrite();
    randomRead(8'h08, "R7 last complete byte stored");

    // R7 stop partway through a later byte
    doStart();
    sendByte(ctrlByte(1'b0), a);
    sendByte(8'h09, a);
    sendByte(8'h33, a);
    sendBits(8'hC0, 3);
    doStop();
    randomRead(8'h09, "R7 partial later byte aborts");

    // R11 low supply inhibits store
    lowSupply = 1'b1;
    byteWrite(8'h0A, 8'h77, "R11 command still acked");
    lowSupply = 1'b0;
    pollAck(a);
    check(a == 1'b1, "R11 no write cycle when inhibited", a, 1);
    randomRead(8'h0A, "R11 word unchanged");

    // constrained random writes and read-backs
    for (int k = 0; k < 12; k++) begin
      logic [7:0] ad, dt;
      ad = 8'($urandom);
      dt = 8'($urandom);
      byteWrite(ad, dt, "R3 random write");
      waitWrite();
      if (k % 3 == 0) currentRead("R4 random current read");
      else randomRead(8'($urandom), "R9 random read");
    end

    // R10 sequential read with wrap
    doStart();
    sendByte(ctrlByte(1'b0), a);
    sendByte(8'h0E, a);
    doStart();
    sendByte(ctrlByte(1'b1), a);
    for (int i = 0; i < 20; i++) begin
      readByte(i != 19, d);
      check(d == refMem[(14 + i) % 16], "R10 sequential byte", d, refMem[(14 + i) % 16]);
    end
    refPtr = (14 + 20) % 16;
    for (int i = 0; i < 9; i++) begin
      clockBit(1'b1, s);
      check(s == 1'b0, "R10 released after master nack", s, 0);
    end
    doStop();
    check(sdaPullDown == 1'b0, "R12 released after stop", sdaPullDown, 0);
    currentRead("R10 pointer after wrapped sequence");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule